// File: doc/BRIEF.md
# Multi-Channel Conversion Strobe Delay

This block drives four sample strobes for a bank of analog-to-digital converters. Each strobe is a programmed, delayed copy of a reference timing event that comes from a pattern sequencer. Choosing a different delay per channel lets each conversion happen once the sensor output has settled, and away from noise spikes that follow the sensor's own clock edges. The delay counts whole periods of the block clock. At a 500 MHz counting clock a step is 2 ns, and the default range of 499,999 steps spans just under one millisecond.

Each channel takes its trigger either from its own trigger pin or from a common trigger pin, as a configuration bit selects. A channel keeps its own countdown, so all four channels can have a trigger in flight at the same time. A single pulse-width field sets how long every strobe stays high. A mode bit per channel decides what happens when a trigger arrives while that channel is still counting down. The channel either drops the trigger and raises an overrun flag, or starts the countdown again from the beginning. All settings are loaded through a simple write-only register port. There is no stream data path, so every pin is a plain control or status level with no valid/ready handshake and no back-pressure.

Top module: `conv_strobe_delay`

## Requirements
- R1: A value written to a delay register (addresses 0 to NUM_CH-1, one per channel) that is larger than DLY_MAX (default 499,999) is stored as DLY_MAX. A trigger on that channel then produces a strobe DLY_MAX cycles later than a zero delay would.
- R2: If a trigger on a channel is sampled at clock edge t while the delay register holds D, the strobe goes high after edge t+D. With D equal to zero, the strobe is high in the cycle right after the trigger.
- R3: The control register is at address 4. Its bits [3:0] hold a value P, and every strobe stays high for exactly P+1 cycles, so the width runs from 1 to 16 cycles.
- R4: Writing a channel's delay register while that channel is counting down does not change the countdown already running. The new value applies from the next accepted trigger.
- R5: Control bit [8+i] set to 1 makes channel i take its trigger from shared_trig_i and ignore trig_i[i]. With the bit at 0, the channel uses trig_i[i] and ignores shared_trig_i.
- R6: Control bit [4+i] at 0 selects drop mode for channel i. In this mode a trigger that arrives while the channel is counting down is ignored, and overrun_o[i] goes high for exactly the one cycle after that trigger.
- R7: Control bit [4+i] at 1 selects restart mode for channel i. In this mode a trigger that arrives while the channel is counting down reloads the countdown with the current delay, and overrun_o[i] stays low.
- R8: The channels work independently. A trigger, countdown or strobe on one channel never changes the timing on any other channel.
- R9: After reset, every strobe and overrun output is low, every delay is zero, and the control register is zero: width 1, drop mode, per-channel triggers.
- R10: A write to addresses 5 to 7 changes no setting and has no effect on the outputs.
- R11: A trigger that arrives while a channel's strobe is still high, but the channel is not counting down, is accepted as a new event without raising overrun. If its delay is zero, the strobe restarts its full width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock; one period is one delay step |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W (3) | Register address: 0 to 3 are the delays, 4 is the control register |
| wr_data_i | input | DLY_W (19) | Register write data |
| trig_i | input | NUM_CH (4) | Trigger pins, one per channel |
| shared_trig_i | input | 1 | Common trigger pin, used by any channel that selects it |
| strobe_o | output | NUM_CH (4) | Conversion strobes |
| overrun_o | output | NUM_CH (4) | One-cycle flag for a trigger dropped in drop mode |

## Verification
The assertions assume that trigger and write inputs change only away from the rising clock edge. They also assume that reset is held for at least one edge before any trigger, so that the previous-cycle terms they use refer to post-reset state. The stimulus drives every input on the falling edge and releases reset only after several cycles. To keep the long-delay case inside the run time, the bench builds the block with a small saturation limit. Delays on the randomized stretch are masked to small values, so overlapping triggers, restarts and overruns occur often and the windows on the assertions are exercised many times.

// File: rtl/csd_pkg.sv
package csd_pkg;
  typedef enum logic {
    CH_IDLE  = 1'b0,
    CH_COUNT = 1'b1
  } csd_state_e;

  localparam int unsigned CSD_CTRL_ADDR = 4;
endpackage

// File: rtl/csd_regs.sv
module csd_regs #(
  parameter int unsigned NUM_CH  = 4,
  parameter int unsigned DLY_W   = 19,
  parameter int unsigned DLY_MAX = 499999,
  parameter int unsigned PW_W    = 4,
  parameter int unsigned ADDR_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [DLY_W-1:0]          wr_data,
  output logic [NUM_CH*DLY_W-1:0]   dly_flat,
  output logic [PW_W-1:0]           pw_val,
  output logic [NUM_CH-1:0]         restart_mode,
  output logic [NUM_CH-1:0]         use_shared
);
  import csd_pkg::*;

  localparam int unsigned        CTRL_W  = PW_W + 2 * NUM_CH;
  localparam logic [DLY_W-1:0]   DLY_CAP = DLY_W'(DLY_MAX);
  localparam logic [ADDR_W-1:0]  CTRL_A  = ADDR_W'(CSD_CTRL_ADDR);

  logic [CTRL_W-1:0] ctrl_q;
  logic [DLY_W-1:0]  capped;

  // Saturate once at write time so every channel sees an in-range value
  always_comb capped = (wr_data > DLY_CAP) ? DLY_CAP : wr_data;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_dly
    logic [DLY_W-1:0] dly_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        dly_q <= '0;
      else if (wr_en && (wr_addr == ADDR_W'(g)))
        dly_q <= capped;
    end
    assign dly_flat[g*DLY_W +: DLY_W] = dly_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      ctrl_q <= '0;
    else if (wr_en && (wr_addr == CTRL_A))
      ctrl_q <= wr_data[CTRL_W-1:0];
  end

  assign pw_val       = ctrl_q[PW_W-1:0];
  assign restart_mode = ctrl_q[PW_W +: NUM_CH];
  assign use_shared   = ctrl_q[PW_W+NUM_CH +: NUM_CH];
endmodule

// File: rtl/csd_trig_sel.sv
module csd_trig_sel #(
  parameter int unsigned NUM_CH = 4
) (
  input  logic [NUM_CH-1:0] trig_pin,
  input  logic              trig_common,
  input  logic [NUM_CH-1:0] use_shared,
  output logic [NUM_CH-1:0] trig_eff
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
    always_comb trig_eff[g] = use_shared[g] ? trig_common : trig_pin[g];
  end
endmodule

// File: rtl/csd_channel.sv
module csd_channel #(
  parameter int unsigned DLY_W = 19,
  parameter int unsigned PW_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic [DLY_W-1:0] dly,
  input  logic [PW_W-1:0]  pw,
  input  logic             restart,
  output logic             strobe,
  output logic             overrun,
  output logic             counting
);
  import csd_pkg::*;

  csd_state_e       state_q;
  logic [DLY_W-1:0] cnt_q;
  logic [PW_W-1:0]  pw_cnt_q;
  logic             strobe_q;
  logic             ovr_q;
  logic             load, drop, fire, dly_zero;

  always_comb begin
    dly_zero = (dly == '0);
    load     = trig && ((state_q == CH_IDLE) || restart);
    drop     = trig && (state_q == CH_COUNT) && !restart;
    if (load)
      fire = dly_zero;
    else
      fire = (state_q == CH_COUNT) && (cnt_q == '0);
  end

  // Countdown: the delay is copied at trigger time, later writes wait
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= CH_IDLE;
      cnt_q   <= '0;
    end else if (load) begin
      if (dly_zero) begin
        state_q <= CH_IDLE;
      end else begin
        state_q <= CH_COUNT;
        cnt_q   <= dly - 1'b1;
      end
    end else if (state_q == CH_COUNT) begin
      if (cnt_q == '0)
        state_q <= CH_IDLE;
      else
        cnt_q <= cnt_q - 1'b1;
    end
  end

  // Pulse shaper: runs beside the countdown so a new event may start
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      pw_cnt_q <= '0;
    end else if (fire) begin
      strobe_q <= 1'b1;
      pw_cnt_q <= pw;
    end else if (strobe_q) begin
      if (pw_cnt_q == '0)
        strobe_q <= 1'b0;
      else
        pw_cnt_q <= pw_cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ovr_q <= 1'b0;
    else        ovr_q <= drop;
  end

  assign strobe   = strobe_q;
  assign overrun  = ovr_q;
  assign counting = (state_q == CH_COUNT);
endmodule

// File: rtl/conv_strobe_delay.sv
module conv_strobe_delay #(
  parameter int unsigned NUM_CH  = 4,
  parameter int unsigned DLY_W   = 19,
  parameter int unsigned DLY_MAX = 499999,
  parameter int unsigned PW_W    = 4,
  parameter int unsigned ADDR_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DLY_W-1:0]  wr_data_i,
  input  logic [NUM_CH-1:0] trig_i,
  input  logic              shared_trig_i,
  output logic [NUM_CH-1:0] strobe_o,
  output logic [NUM_CH-1:0] overrun_o
);
  logic [NUM_CH*DLY_W-1:0] dly_flat;
  logic [PW_W-1:0]         pw_val;
  logic [NUM_CH-1:0]       restart_mode;
  logic [NUM_CH-1:0]       use_shared;
  logic [NUM_CH-1:0]       eff_trig;
  logic [NUM_CH-1:0]       counting;

  csd_regs #(
    .NUM_CH(NUM_CH), .DLY_W(DLY_W), .DLY_MAX(DLY_MAX),
    .PW_W(PW_W), .ADDR_W(ADDR_W)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
    .wr_data(wr_data_i), .dly_flat(dly_flat), .pw_val(pw_val),
    .restart_mode(restart_mode), .use_shared(use_shared)
  );

  csd_trig_sel #(.NUM_CH(NUM_CH)) sel_i (
    .trig_pin(trig_i), .trig_common(shared_trig_i),
    .use_shared(use_shared), .trig_eff(eff_trig)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    csd_channel #(.DLY_W(DLY_W), .PW_W(PW_W)) ch_i (
      .clk(clk), .rst_n(rst_n), .trig(eff_trig[g]),
      .dly(dly_flat[g*DLY_W +: DLY_W]), .pw(pw_val),
      .restart(restart_mode[g]), .strobe(strobe_o[g]),
      .overrun(overrun_o[g]), .counting(counting[g])
    );
  end
endmodule

// File: rtl/csd_chk.sv
module csd_chk #(
  parameter int unsigned NUM_CH  = 4,
  parameter int unsigned DLY_W   = 19,
  parameter int unsigned DLY_MAX = 499999
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUM_CH-1:0]       eff_trig,
  input logic [NUM_CH*DLY_W-1:0] dly_flat,
  input logic [NUM_CH-1:0]       restart,
  input logic [NUM_CH-1:0]       counting,
  input logic [NUM_CH-1:0]       strobe,
  input logic [NUM_CH-1:0]       overrun
);
  localparam logic [DLY_W-1:0] CAP = DLY_W'(DLY_MAX);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_p
    AST_DLY_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
      dly_flat[g*DLY_W +: DLY_W] <= CAP); // R1
    AST_ZERO_DLY_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      eff_trig[g] && (dly_flat[g*DLY_W +: DLY_W] == '0) && (!counting[g] || restart[g])
      |=> strobe[g]); // R2
    AST_RISE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(strobe[g]) |-> ($past(eff_trig[g]) || $past(counting[g]))); // R2
    AST_OVR_ONLY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      overrun[g] |-> ($past(eff_trig[g]) && $past(counting[g]) && !$past(restart[g]))); // R6
    AST_RESTART_NO_OVR: assert property (@(posedge clk) disable iff (!rst_n)
      restart[g] && eff_trig[g] |=> !overrun[g]); // R7
  end
endmodule

bind conv_strobe_delay csd_chk #(
  .NUM_CH(NUM_CH), .DLY_W(DLY_W), .DLY_MAX(DLY_MAX)
) chk_i (
  .clk(clk), .rst_n(rst_n), .eff_trig(eff_trig), .dly_flat(dly_flat),
  .restart(restart_mode), .counting(counting), .strobe(strobe_o),
  .overrun(overrun_o)
);

// File: tb/conv_strobe_delay_tb_top.sv
`timescale 1ns/1ps
module conv_strobe_delay_tb_top;
  localparam int NCH  = 4;
  localparam int DW   = 19;
  localparam int DMAX = 300;
  localparam int PWW  = 4;
  localparam int AW   = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           wr_en = 1'b0;
  logic [AW-1:0]  wr_addr = '0;
  logic [DW-1:0]  wr_data = '0;
  logic [NCH-1:0] trig = '0;
  logic           strig = 1'b0;
  logic [NCH-1:0] strobe, ovr;

  always #2.5 clk = ~clk;

  conv_strobe_delay #(.NUM_CH(NCH), .DLY_W(DW), .DLY_MAX(DMAX), .PW_W(PWW), .ADDR_W(AW))
  dut_i (.clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
         .wr_data_i(wr_data), .trig_i(trig), .shared_trig_i(strig),
         .strobe_o(strobe), .overrun_o(ovr));

  int tests = 0, fails = 0;
  string cur_req = "R9";

  task automatic check(string req, int act, int exp, string what);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Behavioural reference: event times in edge numbers
  int  edge_n = 0;
  int  m_dly[NCH];
  int  m_pw = 0;
  bit  m_rs[NCH], m_sh[NCH], pend[NCH], m_ovr[NCH];
  int  target[NCH], pend_end[NCH];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        m_dly[c] = 0; m_rs[c] = 0; m_sh[c] = 0; pend[c] = 0;
        m_ovr[c] = 0; target[c] = 0; pend_end[c] = -1;
      end
      m_pw = 0;
      edge_n = 0;
    end else begin
      edge_n++;
      for (int c = 0; c < NCH; c++) begin
        bit ev;
        ev = m_sh[c] ? strig : trig[c];
        m_ovr[c] = 0;
        if (ev) begin
          if (pend[c] && !m_rs[c]) m_ovr[c] = 1;
          else begin pend[c] = 1; target[c] = edge_n + m_dly[c]; end
        end
        if (pend[c] && target[c] == edge_n) begin
          pend[c] = 0;
          pend_end[c] = edge_n + m_pw + 1;
        end
      end
      if (wr_en) begin
        if (int'(wr_addr) < NCH)
          m_dly[wr_addr] = (int'(wr_data) > DMAX) ? DMAX : int'(wr_data);
        else if (int'(wr_addr) == 4) begin
          m_pw = int'(wr_data[3:0]);
          for (int c = 0; c < NCH; c++) begin
            m_rs[c] = wr_data[4+c];
            m_sh[c] = wr_data[8+c];
          end
        end
      end
    end
  end

  // Compare every cycle away from the active edge
  always @(negedge clk) begin
    logic [NCH-1:0] es, eo;
    for (int c = 0; c < NCH; c++) begin
      es[c] = rst_n && (edge_n < pend_end[c]);
      eo[c] = rst_n && m_ovr[c];
    end
    check(cur_req, int'(strobe), int'(es), "strobe_o vs model");
    check(cur_req, int'(ovr), int'(eo), "overrun_o vs model");
  end

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; tests++;
      $display("FAIL R8 watchdog: actual %0d cycles expected below 100000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = DW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic fire(logic [NCH-1:0] m, logic s);
    trig = m; strig = s;
    @(negedge clk);
    trig = '0; strig = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // Cycles from trigger to strobe high on channel ch
  task automatic latency(int ch, int exp, string req);
    int n = 0;
    trig[ch] = 1'b1;
    @(negedge clk);
    trig = '0;
    while (!strobe[ch] && n < 1000) begin @(negedge clk); n++; end
    check(req, n, exp, "trigger to strobe latency");
  endtask

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    check("R9", int'(strobe), 0, "strobe in reset");
    check("R9", int'(ovr), 0, "overrun in reset");
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R9";
    latency(0, 0, "R9");
    idle(4);

    cur_req = "R2";
    wr(0, 5);
    latency(0, 5, "R2");
    idle(4);
    wr(0, 0);
    latency(0, 0, "R2");
    idle(4);

    cur_req = "R3";
    wr(4, 15); fire(4'b0001, 0); idle(20);
    wr(4, 2);  fire(4'b0001, 0); idle(6);

    cur_req = "R4";
    wr(1, 20); fire(4'b0010, 0); idle(5);
    wr(1, 3);  idle(25);
    latency(1, 3, "R4");
    idle(6);

    cur_req = "R5";
    wr(4, 'hC02); wr(2, 4); wr(3, 7);
    fire(4'b1100, 0); idle(12);
    fire(4'b0000, 1); idle(12);
    latency(0, 0, "R5");
    idle(4);

    cur_req = "R6";
    wr(4, 0); wr(0, 30);
    fire(4'b0001, 0); idle(5);
    trig[0] = 1'b1; @(negedge clk); trig = '0;
    check("R6", int'(ovr[0]), 1, "overrun after dropped trigger");
    idle(35);

    cur_req = "R7";
    wr(4, 'h10);
    fire(4'b0001, 0); idle(5); fire(4'b0001, 0); idle(40);

    cur_req = "R8";
    wr(4, 0); wr(0, 2); wr(1, 9); wr(2, 0); wr(3, 17);
    fire(4'b1111, 0); idle(25);

    cur_req = "R10";
    wr(6, 'h7FFFF); wr(5, 'h7FFFF); wr(7, 'h12345);
    latency(1, 9, "R10");
    idle(4);

    cur_req = "R11";
    wr(4, 9); wr(0, 0);
    fire(4'b0001, 0); idle(3); fire(4'b0001, 0);
    check("R11", int'(ovr[0]), 0, "no overrun during pulse");
    idle(15);

    cur_req = "R1";
    wr(4, 0); wr(3, 400);
    latency(3, DMAX, "R1");
    idle(4);

    cur_req = "R8";
    for (int i = 0; i < 400; i++) begin
      if (i % 37 == 0) wr(i % 5, $urandom_range(0, 12));
      else if (i % 53 == 0) wr(4, $urandom_range(0, 4095));
      trig = NCH'($urandom_range(0, 15) & $urandom_range(0, 15));
      strig = ($urandom_range(0, 7) == 0);
      @(negedge clk);
    end
    trig = '0; strig = 1'b0;
    idle(40);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule